// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address for a synchronous burst memory. A burst starts when one of two address strobes is seen while the chip-select input is high. One strobe belongs to the processor and the other to the cache controller, and each strobe carries its own address bus. The block registers the full starting address. After that, each clock edge with the advance input high moves the two least-significant address bits one step through a four-word burst. The upper address bits stay fixed for the whole burst.

A mode input sets the order of the burst. A low level gives linear order: the low bits count up from the start and wrap within the aligned group of four. A high level gives interleaved order: the low bits are the start bits XOR a step count that runs 0, 1, 2, 3. The mode is sampled when the burst starts and is kept until the next start. Reset selects interleaved order, the same as an unconnected mode pin. Every input is sampled on the rising clock edge, and the address output is a register.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `addr_out` is zero.
- R2: A rising edge with `chip_sel` and `cpu_strobe` high loads `cpu_addr`, and `addr_out` shows it after that edge.
- R3: A rising edge with `chip_sel` and `ctl_strobe` high and `cpu_strobe` low loads `ctl_addr`.
- R4: When both strobes are high on the same edge, `cpu_addr` is loaded and `ctl_addr` is ignored.
- R5: With `chip_sel` low, both strobes have no effect, and `advance` still steps the current burst.
- R6: In linear order (`mode` = 0 at load), each advance step sets the low two bits to (start + step) mod 4.
- R7: In interleaved order (`mode` = 1 at load), the low two bits are start XOR step, where step counts 0,1,2,3.
- R8: Bits above bit 1 never change during a burst, and no carry passes into them. After four steps the address returns to its start value.
- R9: With no accepted strobe and `advance` low, `addr_out` holds its value.
- R10: An accepted strobe takes priority over `advance` on the same edge and restarts the step count at 0.
- R11: The order is the `mode` value sampled at the strobe. Changes to `mode` in the middle of a burst have no effect until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_sel | input | 1 | Gates both strobes; strobes count only when this is high |
| cpu_strobe | input | 1 | Processor address strobe |
| ctl_strobe | input | 1 | Cache-controller address strobe |
| advance | input | 1 | Steps the burst one word |
| mode | input | 1 | 0 = linear order, 1 = interleaved order |
| cpu_addr | input | AW | Start address presented with the processor strobe |
| ctl_addr | input | AW | Start address presented with the controller strobe |
| addr_out | output | AW | Current registered word address |

## Verification
The bench starts a linear burst at an address ending in binary 11 and advances it. A design that lets the carry out of the low bits reach the upper bits would give 0x1000 where 0x0FFC is expected. The bench starts an interleaved burst at low bits 01, so any accidental use of addition in place of XOR changes the result visibly. It changes `mode` in the middle of a burst, which exposes a design that samples the mode on every edge instead of holding the value from the strobe. It also raises both strobes together with different addresses, raises a strobe together with `advance`, and raises a strobe while `chip_sel` is low. These cases catch a wrong priority, a step on a load edge, and a load that ignores the chip-select gate.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chip_sel,
  input  logic          cpu_strobe,
  input  logic          ctl_strobe,
  input  logic          advance,
  input  logic          mode,
  input  logic [AW-1:0] cpu_addr,
  input  logic [AW-1:0] ctl_addr,
  output logic [AW-1:0] addr_out
);
  localparam int SW = 2;

  logic [AW-1:0] base_q, base_n;
  logic [SW-1:0] step_q, step_n, low_n;
  logic          ilv_q, ilv_n;
  logic          load;

  assign load   = chip_sel & (cpu_strobe | ctl_strobe);
  assign base_n = !load ? base_q : (cpu_strobe ? cpu_addr : ctl_addr);
  assign ilv_n  = load ? mode : ilv_q;
  assign step_n = load ? '0 : (advance ? step_q + 1'b1 : step_q);
  assign low_n  = ilv_n ? (base_n[SW-1:0] ^ step_n) : (base_n[SW-1:0] + step_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      step_q   <= '0;
      ilv_q    <= 1'b1;
      addr_out <= '0;
    end else begin
      base_q   <= base_n;
      step_q   <= step_n;
      ilv_q    <= ilv_n;
      addr_out <= {base_n[AW-1:SW], low_n};
    end
  end
endmodule

module burst_addr_gen_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chip_sel,
  input logic          cpu_strobe,
  input logic          ctl_strobe,
  input logic          advance,
  input logic [AW-1:0] cpu_addr,
  input logic [AW-1:0] ctl_addr,
  input logic [AW-1:0] addr_out
);
  logic took;
  assign took = chip_sel && (cpu_strobe || ctl_strobe);

  // R2 and R4
  a_r2_cpu_load: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_sel && cpu_strobe) |=> addr_out == $past(cpu_addr));
  // R3
  a_r3_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_sel && !cpu_strobe && ctl_strobe) |=> addr_out == $past(ctl_addr));
  // R9 and R5
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!took && !advance) |=> $stable(addr_out));
  // R8
  a_r8_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (!took && advance) |=> addr_out[AW-1:2] == $past(addr_out[AW-1:2]));
  // R6 and R7: every step moves the low bits
  a_r6_step_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (!took && advance) |=> addr_out[1:0] != $past(addr_out[1:0]));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .chip_sel(chip_sel), .cpu_strobe(cpu_strobe),
  .ctl_strobe(ctl_strobe), .advance(advance), .cpu_addr(cpu_addr),
  .ctl_addr(ctl_addr), .addr_out(addr_out)
);

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
  localparam int AW = 16;
  localparam int NV = 21;

  logic clk = 1'b0, rst_n = 1'b0;
  logic chip_sel = 0, cpu_strobe = 0, ctl_strobe = 0, advance = 0, mode = 1;
  logic [AW-1:0] cpu_addr = '0, ctl_addr = '0, addr_out;
  int checks = 0, fails = 0;
  bit done = 0;

  burst_addr_gen #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .chip_sel(chip_sel), .cpu_strobe(cpu_strobe),
    .ctl_strobe(ctl_strobe), .advance(advance), .mode(mode),
    .cpu_addr(cpu_addr), .ctl_addr(ctl_addr), .addr_out(addr_out)
  );

  always #10 clk = ~clk;

  // {chip_sel, cpu_strobe, ctl_strobe, advance, mode, cpu_addr, ctl_addr, expected}
  localparam logic [52:0] VEC [NV] = '{
    {5'b11000, 16'h1232, 16'h0000, 16'h1232}, // R2 load, linear
    {5'b10010, 16'h0000, 16'h0000, 16'h1233}, // R6
    {5'b10010, 16'h0000, 16'h0000, 16'h1230}, // R6 wrap
    {5'b10010, 16'h0000, 16'h0000, 16'h1231}, // R6
    {5'b10010, 16'h0000, 16'h0000, 16'h1232}, // R8 back to start
    {5'b10000, 16'h0000, 16'h0000, 16'h1232}, // R9 hold
    {5'b10101, 16'h0000, 16'hABC1, 16'hABC1}, // R3 load, interleaved
    {5'b10011, 16'h0000, 16'h0000, 16'hABC0}, // R7
    {5'b10011, 16'h0000, 16'h0000, 16'hABC3}, // R7
    {5'b10011, 16'h0000, 16'h0000, 16'hABC2}, // R7
    {5'b10011, 16'h0000, 16'h0000, 16'hABC1}, // R8 back to start
    {5'b11100, 16'h5556, 16'h7777, 16'h5556}, // R4 both strobes
    {5'b10010, 16'h0000, 16'h0000, 16'h5557}, // R6
    {5'b01000, 16'h9999, 16'h0000, 16'h5557}, // R5 gated strobe
    {5'b00110, 16'h0000, 16'h8888, 16'h5554}, // R5 gated, advance works
    {5'b11011, 16'h00FD, 16'h0000, 16'h00FD}, // R10 strobe beats advance
    {5'b10010, 16'h0000, 16'h0000, 16'h00FC}, // R11 mode held interleaved
    {5'b10010, 16'h0000, 16'h0000, 16'h00FF}, // R11
    {5'b11000, 16'h0FFF, 16'h0000, 16'h0FFF}, // R2 linear at top
    {5'b10010, 16'h0000, 16'h0000, 16'h0FFC}, // R8 no carry
    {5'b10000, 16'h0000, 16'h0000, 16'h0FFC}  // R9 hold
  };
  localparam int REQ [NV] = '{2,6,6,6,8,9,3,7,7,7,8,4,6,5,5,10,11,11,2,8,9};

  task automatic check(input int req, input logic [AW-1:0] exp);
    checks++;
    if (addr_out !== exp) begin
      fails++;
      $display("FAIL R%0d: addr_out=%h expected=%h", req, addr_out, exp);
    end
  endtask

  task automatic drive(input logic [52:0] v);
    {chip_sel, cpu_strobe, ctl_strobe, advance, mode} = v[52:48];
    cpu_addr = v[47:32];
    ctl_addr = v[31:16];
  endtask

  initial begin
    #35;
    check(1, '0); // R1 during reset
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk) #5 check(1, '0); // R1 first cycle after reset
    for (int i = 0; i < NV; i++) begin
      @(negedge clk) drive(VEC[i]);
      @(posedge clk) #5 check(REQ[i], VEC[i][15:0]);
    end
    @(negedge clk) begin
      drive({5'b10010, 16'h0, 16'h0, 16'h0});
      rst_n = 1'b0;
    end
    #2 check(1, '0); // R1 reset in mid-run
    @(posedge clk) #5 check(1, '0); // R1 advance ignored under reset
    @(negedge clk) begin
      rst_n = 1'b1;
      drive({5'b00000, 16'h0, 16'h0, 16'h0});
    end
    @(posedge clk) #5 check(9, '0); // R9
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule